// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display: a pixel-column counter, a line counter, horizontal and vertical sync, a blanking signal and an active-video qualifier. Each axis is programmed through one packed 32-bit word. The word holds four segment lengths, a polarity bit and a sync-suppress bit. Horizontal lengths are counted in groups of four pixels, and vertical lengths in whole lines. A separate two-bit control word starts scanning and can force the picture to blank.

Software writes and reads these words through a simple register port. The port also gives access to a sticky status flag that marks the start of vertical retrace. Software clears the flag by writing a 1 to it. The segment words are buffered: a new value written while scanning does not disturb the frame on screen and is used from the next frame onward. Setting the suppress bit on one axis, or on both, gives the usual display power-saving states of hsync off, vsync off and both off.

Top module: `rasterTimingGen`

## Requirements
- R1: The horizontal word (address 0) holds the active width in quads. Bits [8:0] are its low part and bits [29:28] are its two top bits. The front porch is in bits [13:9], the sync width in [20:14] and the back porch in [27:21]. Every quad counts as 4 pixel columns.
- R2: The vertical word (address 1) holds the active lines in [10:0], the front porch in [15:11], the sync width in [21:16] and the back porch in [27:22]. All of these are counted in lines.
- R3: On each axis the regions follow one another as active, front porch, sync, back porch. pixCol advances by one every clock and wraps to 0 after the last back-porch column. lineNum advances when pixCol wraps and returns to 0 after the last line. activeVideo is 1 only where both axes are in their active region.
- R4: Bit 31 of a timing word selects the sync polarity for that axis. When it is 1 the sync output is high inside the sync region and low elsewhere. When it is 0 these levels are inverted.
- R5: Bit 30 of a timing word suppresses the sync pulse for that axis, so its output stays at the inactive level for the whole frame. The other axis is not affected.
- R6: The control word (address 2) uses bit 0 as scan enable and bit 1 as force-blank. With enable set, blank is 1 outside the visible area and 0 inside it. With force-blank also set, blank is 1 on every clock and activeVideo is 0.
- R7: While scan enable is 0, pixCol and lineNum stay at 0, both syncs sit at their inactive levels, and blank and activeVideo are 0.
- R8: A timing word written while scanning takes effect at the first clock of the next frame. A timing word written while idle takes effect on the following clock.
- R9: The retrace flag becomes 1 on the clock after the counters show column 0 of the first vertical-sync line, provided the vertical sync width is not zero. It then stays at 1.
- R10: Writing 1 to bit 0 of address 3 clears the retrace flag. Writing 0 there leaves the flag unchanged.
- R11: Reads are combinational. Addresses 0 and 1 return the last word written to them. Address 2 returns the two control bits in [1:0]. Address 3 returns the retrace flag in bit 0. All other bits read as zero.
- R12: After reset, all registers and the retrace flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 horiz, 1 vert, 2 control, 3 status) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| pixCol | output | PIX_W | Current pixel column |
| lineNum | output | LINE_W | Current line |
| hsync | output | 1 | Horizontal sync, polarity per bit 31 of the horizontal word |
| vsync | output | 1 | Vertical sync, polarity per bit 31 of the vertical word |
| blank | output | 1 | Blanking active |
| activeVideo | output | 1 | Visible pixel qualifier |
| retraceFlag | output | 1 | Sticky vertical retrace status |

## Verification
All video outputs are decoded combinationally from the registered counters. After the edge that accepts the enable write, the sample at the next falling edge shows position 0, and every later falling edge shows the next position. The bench therefore steps an arithmetic position model once per clock and compares every output at the falling edge. The retrace flag is expected one sample after the model reaches the first sync line. A timing word written mid-frame is applied in the model only at its own frame wrap. While idle, new polarity is expected one clock after the write edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Per-axis timing, lengths in axis units (quads or lines)
  typedef struct packed {
    logic [10:0] act;
    logic [6:0]  fp;
    logic [6:0]  sync;
    logic [6:0]  bp;
    logic        syncOff;
    logic        syncHigh;
  } axisCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;
    logic forceBlank;
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_HORIZ = 2'd0;
  localparam logic [1:0] ADDR_VERT  = 2'd1;
  localparam logic [1:0] ADDR_VALID = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  function automatic axisCfg_t decodeHoriz(input logic [31:0] w);
    axisCfg_t c;
    c.act      = {w[29:28], w[8:0]};
    c.fp       = {2'b00, w[13:9]};
    c.sync     = w[20:14];
    c.bp       = w[27:21];
    c.syncOff  = w[30];
    c.syncHigh = w[31];
    return c;
  endfunction

  function automatic axisCfg_t decodeVert(input logic [31:0] w);
    axisCfg_t c;
    c.act      = w[10:0];
    c.fp       = {2'b00, w[15:11]};
    c.sync     = {1'b0, w[21:16]};
    c.bp       = {1'b0, w[27:22]};
    c.syncOff  = w[30];
    c.syncHigh = w[31];
    return c;
  endfunction

endpackage

// File: rtl/rtgAxis.sv
module rtgAxis
  import rtg_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int SHIFT   = 2,
  parameter bit MARK_AT_SYNC = 1'b0
) (
  input  axisCfg_t         cfg,
  input  logic [CNT_W-1:0] pos,
  output logic             inActive,
  output logic             inSync,
  output logic             atEnd,
  output logic             mark
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] actLen, fpLen, syncLen, bpLen;
  logic [SUM_W-1:0] actEnd, fpEnd, syncEnd, total, posExt;

  assign actLen  = SUM_W'(cfg.act)  << SHIFT;
  assign fpLen   = SUM_W'(cfg.fp)   << SHIFT;
  assign syncLen = SUM_W'(cfg.sync) << SHIFT;
  assign bpLen   = SUM_W'(cfg.bp)   << SHIFT;

  assign actEnd  = actLen;
  assign fpEnd   = actEnd + fpLen;
  assign syncEnd = fpEnd + syncLen;
  assign total   = syncEnd + bpLen;
  assign posExt  = {1'b0, pos};

  assign inActive = posExt < actEnd;
  assign inSync   = (posExt >= fpEnd) && (posExt < syncEnd);
  assign atEnd    = (posExt + 1'b1) >= total;

  generate
    if (MARK_AT_SYNC) begin : g_syncMark
      assign mark = (posExt == fpEnd) && (cfg.sync != '0);
    end else begin : g_originMark
      assign mark = (pos == '0);
    end
  endgenerate

endmodule

// File: rtl/rtgDatapath.sv
module rtgDatapath
  import rtg_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  axisCfg_t          hCfg,
  input  axisCfg_t          vCfg,
  output logic [PIX_W-1:0]  pixCol,
  output logic [LINE_W-1:0] lineNum,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              activeVideo,
  output logic              frameEnd,
  output logic              retraceStart
);
  logic hAct, hSync, hEnd, hOrigin;
  logic vAct, vSync, vEnd, vLead;
  logic visible;

  rtgAxis #(.CNT_W(PIX_W), .SHIFT(2), .MARK_AT_SYNC(1'b0)) uHoriz (
    .cfg(hCfg), .pos(pixCol),
    .inActive(hAct), .inSync(hSync), .atEnd(hEnd), .mark(hOrigin)
  );

  rtgAxis #(.CNT_W(LINE_W), .SHIFT(0), .MARK_AT_SYNC(1'b1)) uVert (
    .cfg(vCfg), .pos(lineNum),
    .inActive(vAct), .inSync(vSync), .atEnd(vEnd), .mark(vLead)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCol  <= '0;
      lineNum <= '0;
    end else if (!stb.run) begin
      pixCol  <= '0;
      lineNum <= '0;
    end else if (hEnd) begin
      pixCol  <= '0;
      lineNum <= vEnd ? '0 : lineNum + 1'b1;
    end else begin
      pixCol  <= pixCol + 1'b1;
    end
  end

  assign visible      = hAct && vAct;
  assign hsync        = (stb.run && hSync && !hCfg.syncOff) ? hCfg.syncHigh : ~hCfg.syncHigh;
  assign vsync        = (stb.run && vSync && !vCfg.syncOff) ? vCfg.syncHigh : ~vCfg.syncHigh;
  assign activeVideo  = stb.run && visible && !stb.forceBlank;
  assign blank        = stb.run && (!visible || stb.forceBlank);
  assign frameEnd     = stb.run && hEnd && vEnd;
  assign retraceStart = stb.run && hOrigin && vLead;

endmodule

// File: rtl/rtgControl.sv
module rtgControl
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        frameEnd,
  input  logic        retraceStart,
  output ctrlStrobe_t stb,
  output axisCfg_t    hCfg,
  output axisCfg_t    vCfg,
  output logic        retraceFlag
);
  logic [31:0] hPend, vPend;
  logic [1:0]  validBits;
  logic        clrHit;

  assign clrHit = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPend     <= '0;
      vPend     <= '0;
      validBits <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_HORIZ: hPend     <= regWrData;
        ADDR_VERT:  vPend     <= regWrData;
        ADDR_VALID: validBits <= regWrData[1:0];
        default:    ;
      endcase
    end
  end

  // Working copies: follow pending words while idle, else only at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCfg <= '0;
      vCfg <= '0;
    end else if (!stb.run || frameEnd) begin
      hCfg <= decodeHoriz(hPend);
      vCfg <= decodeVert(vPend);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             retraceFlag <= 1'b0;
    else if (retraceStart) retraceFlag <= 1'b1;
    else if (clrHit)       retraceFlag <= 1'b0;
  end

  assign stb.run        = validBits[0];
  assign stb.forceBlank = validBits[1];

  always_comb begin
    case (regAddr)
      ADDR_HORIZ: regRdData = hPend;
      ADDR_VERT:  regRdData = vPend;
      ADDR_VALID: regRdData = {30'd0, validBits};
      default:    regRdData = {31'd0, retraceFlag};
    endcase
  end

endmodule

// File: rtl/rasterTimingGen.sv
module rasterTimingGen
  import rtg_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [PIX_W-1:0]  pixCol,
  output logic [LINE_W-1:0] lineNum,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              activeVideo,
  output logic              retraceFlag
);
  ctrlStrobe_t ctrlStb;
  axisCfg_t    hCfg, vCfg;
  logic        frameEnd, retraceStart, runEn;

  assign runEn = ctrlStb.run;

  rtgControl uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameEnd(frameEnd), .retraceStart(retraceStart),
    .stb(ctrlStb), .hCfg(hCfg), .vCfg(vCfg), .retraceFlag(retraceFlag)
  );

  rtgDatapath #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .hCfg(hCfg), .vCfg(vCfg),
    .pixCol(pixCol), .lineNum(lineNum), .hsync(hsync), .vsync(vsync),
    .blank(blank), .activeVideo(activeVideo),
    .frameEnd(frameEnd), .retraceStart(retraceStart)
  );

endmodule

// File: rtl/rtgChecker.sv
module rtgChecker #(
  parameter int PIX_W  = 14,
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              retraceStart,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic [PIX_W-1:0]  pixCol,
  input logic [LINE_W-1:0] lineNum,
  input logic              blank,
  input logic              activeVideo,
  input logic              retraceFlag
);
  logic clrWrite;
  assign clrWrite = regWrEn && (regAddr == 2'd3) && regWrData[0];

  p_idle_counters_r7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (pixCol == '0 && lineNum == '0));

  p_idle_outputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!blank && !activeVideo));

  p_blank_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> !blank);

  p_pix_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> (pixCol == '0 || pixCol == $past(pixCol) + 1'b1));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> (pixCol == '0 || $stable(lineNum)));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    retraceStart |=> retraceFlag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retraceFlag && !clrWrite) |=> retraceFlag);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !retraceStart) |=> !retraceFlag);

endmodule

bind rasterTimingGen rtgChecker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uChk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .retraceStart(retraceStart),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .pixCol(pixCol), .lineNum(lineNum), .blank(blank),
  .activeVideo(activeVideo), .retraceFlag(retraceFlag)
);

// File: tb/rasterTimingGen_test.sv
module rasterTimingGen_test;
  localparam int PIX_W  = 14;
  localparam int LINE_W = 12;

  typedef struct {
    int hA, hF, hS, hB, hOff, hPol;
    int vA, vF, vS, vB, vOff, vPol;
  } tcfg_t;

  logic clk = 1'b0;
  logic rstN;
  logic regWrEn;
  logic [1:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic [PIX_W-1:0] pixCol;
  logic [LINE_W-1:0] lineNum;
  logic hsync, vsync, blank, activeVideo, retraceFlag;

  int checks = 0;
  int errors = 0;

  tcfg_t cur, pend;
  int ePix, eLine, forceB;
  logic flagExp;

  always #4 clk = ~clk;

  rasterTimingGen #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixCol(pixCol),
    .lineNum(lineNum), .hsync(hsync), .vsync(vsync), .blank(blank),
    .activeVideo(activeVideo), .retraceFlag(retraceFlag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] packH(input tcfg_t c);
    logic [31:0] w = '0;
    w[8:0] = c.hA[8:0]; w[29:28] = c.hA[10:9];
    w[13:9] = c.hF[4:0]; w[20:14] = c.hS[6:0]; w[27:21] = c.hB[6:0];
    w[30] = c.hOff[0]; w[31] = c.hPol[0];
    return w;
  endfunction

  function automatic logic [31:0] packV(input tcfg_t c);
    logic [31:0] w = '0;
    w[10:0] = c.vA[10:0]; w[15:11] = c.vF[4:0]; w[21:16] = c.vS[5:0]; w[27:22] = c.vB[5:0];
    w[30] = c.vOff[0]; w[31] = c.vPol[0];
    return w;
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkOutputs();
    int hAct, hIn, vAct, vIn, vis;
    hAct = (ePix < 4*cur.hA);
    hIn  = (ePix >= 4*(cur.hA+cur.hF)) && (ePix < 4*(cur.hA+cur.hF+cur.hS));
    vAct = (eLine < cur.vA);
    vIn  = (eLine >= cur.vA+cur.vF) && (eLine < cur.vA+cur.vF+cur.vS);
    vis  = hAct && vAct;
    chk("R1", "pixCol", 32'(pixCol), ePix);
    chk("R2", "lineNum", 32'(lineNum), eLine);
    chk(cur.hOff ? "R5" : "R4", "hsync", 32'(hsync), (hIn && !cur.hOff) ? cur.hPol : 1 - cur.hPol);
    chk(cur.vOff ? "R5" : "R4", "vsync", 32'(vsync), (vIn && !cur.vOff) ? cur.vPol : 1 - cur.vPol);
    chk("R3", "activeVideo", 32'(activeVideo), (vis && !forceB) ? 1 : 0);
    chk("R6", "blank", 32'(blank), (!vis || forceB) ? 1 : 0);
    chk("R9", "retraceFlag", 32'(retraceFlag), 32'(flagExp));
  endtask

  task automatic advance();
    if (ePix == 0 && eLine == cur.vA + cur.vF && cur.vS != 0) flagExp = 1'b1;
    ePix++;
    if (ePix >= 4*(cur.hA+cur.hF+cur.hS+cur.hB)) begin
      ePix = 0;
      eLine++;
      if (eLine >= cur.vA+cur.vF+cur.vS+cur.vB) begin
        eLine = 0;
        cur = pend;
      end
    end
  endtask

  // Sweep n clocks; optionally write a horizontal word during clock wrAt
  task automatic sweep(input int n, input int wrAt, input tcfg_t nxt);
    for (int i = 0; i < n; i++) begin
      checkOutputs();
      if (i == wrAt) begin
        regWrEn = 1'b1; regAddr = 2'd0; regWrData = packH(nxt);
      end else begin
        regWrEn = 1'b0;
      end
      advance();
      if (i == wrAt) pend = nxt;
      @(negedge clk);
    end
    regWrEn = 1'b0;
  endtask

  task automatic configure(input tcfg_t c, input int fb);
    writeReg(2'd2, 32'd0);
    writeReg(2'd0, packH(c));
    writeReg(2'd1, packV(c));
    cur = c; pend = c;
    writeReg(2'd2, {30'd0, fb[0], 1'b1});
    ePix = 0; eLine = 0; forceB = fb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tcfg_t a, b, c;
    a = '{hA:4, hF:1, hS:2, hB:1, hOff:0, hPol:0, vA:3, vF:1, vS:1, vB:2, vOff:0, vPol:1};
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; flagExp = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 / R7: reset state
    chk("R12", "pixCol", 32'(pixCol), 0);
    chk("R12", "lineNum", 32'(lineNum), 0);
    chk("R7", "hsync idle", 32'(hsync), 1);
    chk("R7", "vsync idle", 32'(vsync), 1);
    chk("R7", "blank idle", 32'(blank), 0);
    chk("R7", "activeVideo idle", 32'(activeVideo), 0);
    chk("R12", "retraceFlag", 32'(retraceFlag), 0);
    for (int k = 0; k < 4; k++) begin
      regAddr = k[1:0]; #1;
      chk("R12", "regRdData", regRdData, 0);
    end

    // Main timing, two full frames
    configure(a, 0);
    sweep(448, -1, a);

    // R11: readback while running
    regAddr = 2'd0; #1; chk("R11", "read horiz", regRdData, packH(a));
    regAddr = 2'd1; #1; chk("R11", "read vert", regRdData, packV(a));
    regAddr = 2'd2; #1; chk("R11", "read control", regRdData, 32'd1);
    regAddr = 2'd3; #1; chk("R11", "read status", regRdData, 32'd1);
    @(negedge clk); advance();

    // R8: mid-frame write applies at next frame
    b = a; b.hA = 2; b.hF = 2; b.hS = 1; b.hB = 5; b.hPol = 1;
    // finish the current frame so the sweep starts at position 0
    while (!(ePix == 0 && eLine == 0)) begin @(negedge clk); advance(); end
    sweep(224 + 280, 10, b);

    // R7: disable holds counters and outputs
    writeReg(2'd2, 32'd0);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk("R7", "pixCol held", 32'(pixCol), 0);
      chk("R7", "lineNum held", 32'(lineNum), 0);
      chk("R7", "hsync inactive", 32'(hsync), 0);
      chk("R7", "vsync inactive", 32'(vsync), 0);
      chk("R7", "blank", 32'(blank), 0);
      chk("R7", "activeVideo", 32'(activeVideo), 0);
      @(negedge clk);
    end
    // R8: idle write takes effect next clock
    writeReg(2'd0, packH(a));
    @(negedge clk);
    chk("R8", "idle polarity update", 32'(hsync), 1);

    // R10: write 0 keeps flag, write 1 clears it
    chk("R9", "flag after frames", 32'(retraceFlag), 1);
    writeReg(2'd3, 32'd0);
    chk("R10", "flag kept by 0 write", 32'(retraceFlag), 1);
    writeReg(2'd3, 32'd1);
    chk("R10", "flag cleared", 32'(retraceFlag), 0);
    regAddr = 2'd3; #1; chk("R10", "status read after clear", regRdData, 0);
    flagExp = 1'b0;

    // R6: forced blank
    configure(a, 1);
    sweep(224, -1, a);

    // R5: hsync suppressed, then both suppressed
    c = a; c.hOff = 1;
    configure(c, 0);
    sweep(224, -1, c);
    c.vOff = 1; c.hPol = 1;
    configure(c, 0);
    sweep(224, -1, c);

    // R1: active width using the top field bits
    c = '{hA:512, hF:1, hS:1, hB:1, hOff:0, hPol:1, vA:1, vF:1, vS:1, vB:1, vOff:0, vPol:0};
    configure(c, 0);
    sweep(2060*4, -1, c);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule